// File: doc/BRIEF.md
# Buffered Synchronous Serial Port

This block is a clock-generating serial master built around one shift register of `DW` bits, with a transmit holding register in front of it and a receive holding register behind it. Software-side logic writes a byte into the transmit holding register. The byte moves into the shift register when a frame starts. When the frame ends, the shifted-in byte is copied to the receive holding register and a one-cycle interrupt pulse is raised. Because the two holding registers are separate from the shift register, the next byte can be written while the current frame is still shifting.

The shift clock advances one half-bit per `shift_tick` pulse. The port has three frame formats:
- A plain synchronous format for feeding modulators or demodulators, with a push-pull data output.
- A two-wire format with start, stop and a ninth acknowledge clock.
- The same two-wire format without the acknowledge clock.

In the two-wire formats the data line is open-drain: the block only ever pulls it low. The `hold` control keeps the port inactive. Raising `hold` in the middle of a frame stops the clock at once and keeps the partial contents of the shift register.

Top module: `bss_top`

## Requirements
- R1: After reset `busy`=0, `sck`=1, `tx_ready`=0, `irq`=0, `rxb`=0, `ack_rcvd`=0 and `sd_oe`=0.
- R2: While `hold`=1 no frame starts, `sck` stays 1 and `busy` stays 0, even with a byte pending.
- R3: A `txb_wr` pulse sets `tx_ready` on the next cycle, including while a frame is running. Starting a transmit frame moves the pending byte into the shift register and clears `tx_ready`. A write in the same cycle as that start leaves `tx_ready` set with the new byte pending, while the frame carries the older byte.
- R4: With `dir_tx`=1 a frame starts only when `tx_ready`=1. With `dir_tx`=0, frames start back to back for as long as `hold`=0.
- R5: With `mode`=0 (3 behaves the same), a frame is 8 rising edges of `sck` with no start or stop. Data is sent most significant bit first and changes only while `sck` is low. `sd_in` is sampled on each rising edge. `sd_oe` is 1 during transmit frames and 0 during receive frames.
- R6: At the end of a frame, `rxb` holds the bits sampled during that frame, and `irq` is high for exactly one cycle, in the cycle after the last phase.
- R7: Raising `hold` while `busy`=1 ends the frame on the next edge: `sck` returns to 1, and `rxb` receives the bits sampled so far, right-aligned. No `irq` is raised.
- R8: With `mode`=1 or 2 (two-wire), each frame begins with a fall of the data line while `sck` is high and ends with a rise of the data line while `sck` is high. During the frame `sd_out` is 0 and `sd_oe`=1 means the line is pulled low.
- R9: With `mode`=1, a ninth clock follows the data. In a transmit frame the block releases the line and stores the sampled level in `ack_rcvd` (0 = acknowledged). In a receive frame it drives the level of `ack_send`, and `ack_rcvd` keeps its value.
- R10: With `mode`=2 there is no ninth clock: a frame has 8 data rises plus the stop rise, and `ack_rcvd` is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_tick | input | 1 | One pulse advances the shift clock by a half bit |
| hold | input | 1 | 1 keeps the port inactive and aborts a running frame |
| dir_tx | input | 1 | 1 selects transmit, 0 selects receive |
| mode | input | 2 | 0/3 synchronous, 1 two-wire with acknowledge, 2 two-wire without |
| ack_send | input | 1 | Acknowledge level driven in receive frames of mode 1 |
| txb_wr | input | 1 | Write strobe for the transmit holding register |
| txb_data | input | DW | Byte to transmit |
| sd_in | input | 1 | Serial data input (line level in two-wire modes) |
| sd_out | output | 1 | Serial data output value |
| sd_oe | output | 1 | Output enable for the data pad |
| sck | output | 1 | Shift clock, high when idle |
| rxb | output | DW | Receive holding register |
| tx_ready | output | 1 | A byte waits in the transmit holding register |
| busy | output | 1 | A frame is in progress |
| ack_rcvd | output | 1 | Acknowledge level seen in the last mode-1 transmit frame |
| irq | output | 1 | One-cycle pulse when a frame completes |

## Verification
Two functions can fall in the same cycle: a write to the transmit holding register, and the start of a frame taking the previous byte from that register. The bench keeps a byte pending across a frame end. It then times a second write so that it lands on the very edge where the next frame starts. That edge lies two cycles after the end of the frame, counted from the visible interrupt pulse. The result is judged at the ports: `tx_ready` must still be 1 right after the start, the frame must carry the older byte, and a further frame must carry the newer one.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_BLO   = 3'd2,
    ST_BHI   = 3'd3,
    ST_PLO   = 3'd4,
    ST_PHI   = 3'd5
  } bss_state_e;

  localparam logic [1:0] MODE_SYNC     = 2'd0;
  localparam logic [1:0] MODE_TW_ACK   = 2'd1;
  localparam logic [1:0] MODE_TW_NOACK = 2'd2;

  // Two-wire framing (start, stop, open-drain data)
  function automatic logic is_two_wire(input logic [1:0] m);
    return (m == MODE_TW_ACK) || (m == MODE_TW_NOACK);
  endfunction

  // Number of clocked bits per frame, acknowledge included
  function automatic int unsigned frame_bits(input logic [1:0] m, input int unsigned dw);
    return (m == MODE_TW_ACK) ? dw + 1 : dw;
  endfunction

  // Level the block wants on the data line in the current phase
  function automatic logic line_level(input logic line_low, input logic data_phase,
                                      input logic in_ack, input logic dir_q,
                                      input logic tx_bit, input logic ack_send);
    if (line_low) return 1'b0;
    if (!data_phase) return 1'b1;
    if (in_ack) return dir_q ? 1'b1 : ack_send;
    return dir_q ? tx_bit : 1'b1;
  endfunction

endpackage

// File: rtl/bss_txbuf.sv
module bss_txbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic [DW-1:0] hold_data,
  output logic          ready
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      ready     <= 1'b0;
    end else begin
      if (wr) begin
        hold_data <= wdata;
        ready     <= 1'b1;
      end else if (take) begin
        ready <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bss_shifter.sv
module bss_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic          load_tx,
  input  logic [DW-1:0] load_val,
  input  logic          tx_q,
  input  logic          bit_cap_ev,
  input  logic          ack_cap_ev,
  input  logic          advance_ev,
  input  logic          latch_ev,
  input  logic          sd_in,
  output logic          tx_bit,
  output logic [DW-1:0] rxb,
  output logic          ack_rcvd
);

  logic [DW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      tx_bit   <= 1'b1;
      rxb      <= '0;
      ack_rcvd <= 1'b0;
    end else begin
      if (load_ev) begin
        sr     <= load_tx ? load_val : '0;
        tx_bit <= load_tx ? load_val[DW-1] : 1'b1;
      end
      if (bit_cap_ev) sr <= {sr[DW-2:0], sd_in};
      // next output bit is presented while the clock is low
      if (advance_ev) tx_bit <= tx_q ? sr[DW-1] : 1'b1;
      if (ack_cap_ev) ack_rcvd <= sd_in;
      if (latch_ev) rxb <= sr;
    end
  end

endmodule

// File: rtl/bss_seq.sv
module bss_seq
  import bss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hold,
  input  logic       dir_tx,
  input  logic [1:0] mode,
  input  logic       tx_ready,
  output logic       load_ev,
  output logic       bit_cap_ev,
  output logic       ack_cap_ev,
  output logic       advance_ev,
  output logic       done_ev,
  output logic       abort_ev,
  output logic       busy,
  output logic       scl,
  output logic       tw_q,
  output logic       dir_q,
  output logic       line_low,
  output logic       data_phase,
  output logic       in_ack
);

  localparam int CNT_W = $clog2(DW + 2);

  bss_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mode_q;
  logic             step;
  logic             last_bit;

  assign step       = tick & ~hold;
  assign tw_q       = is_two_wire(mode_q);
  assign last_bit   = (cnt == CNT_W'(frame_bits(mode_q, DW) - 1));
  assign in_ack     = (cnt == CNT_W'(DW));
  assign busy       = (st != ST_IDLE);
  assign scl        = !((st == ST_BLO) || (st == ST_PLO));
  assign line_low   = (st == ST_START) || (st == ST_PLO) || (st == ST_PHI);
  assign data_phase = (st == ST_BLO) || (st == ST_BHI);

  assign load_ev    = (st == ST_IDLE) & step & (~dir_tx | tx_ready);
  assign bit_cap_ev = step & (st == ST_BLO) & ~in_ack;
  assign ack_cap_ev = step & (st == ST_BLO) & in_ack & dir_q;
  assign advance_ev = step & (st == ST_BHI) & ~last_bit;
  assign done_ev    = step & (((st == ST_BHI) & last_bit & ~tw_q) | (st == ST_PHI));
  assign abort_ev   = hold & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode_q <= MODE_SYNC;
      dir_q  <= 1'b0;
    end else if (abort_ev) begin
      st <= ST_IDLE;
    end else if (load_ev) begin
      st     <= is_two_wire(mode) ? ST_START : ST_BLO;
      cnt    <= '0;
      mode_q <= mode;
      dir_q  <= dir_tx;
    end else if (step) begin
      case (st)
        ST_START: st <= ST_BLO;
        ST_BLO:   st <= ST_BHI;
        ST_BHI: begin
          if (last_bit) begin
            st <= tw_q ? ST_PLO : ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
            st  <= ST_BLO;
          end
        end
        ST_PLO:   st <= ST_PHI;
        ST_PHI:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bss_top.sv
module bss_top
  import bss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_tick,
  input  logic          hold,
  input  logic          dir_tx,
  input  logic [1:0]    mode,
  input  logic          ack_send,
  input  logic          txb_wr,
  input  logic [DW-1:0] txb_data,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe,
  output logic          sck,
  output logic [DW-1:0] rxb,
  output logic          tx_ready,
  output logic          busy,
  output logic          ack_rcvd,
  output logic          irq
);

  logic          load_ev, bit_cap_ev, ack_cap_ev, advance_ev, done_ev, abort_ev;
  logic          tw_q, dir_q, line_low, data_phase, in_ack;
  logic          tx_bit, want, take;
  logic [DW-1:0] pend;

  assign take = load_ev & dir_tx;

  bss_txbuf #(.DW(DW)) u_txbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (txb_wr),
    .wdata     (txb_data),
    .take      (take),
    .hold_data (pend),
    .ready     (tx_ready)
  );

  bss_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (shift_tick),
    .hold       (hold),
    .dir_tx     (dir_tx),
    .mode       (mode),
    .tx_ready   (tx_ready),
    .load_ev    (load_ev),
    .bit_cap_ev (bit_cap_ev),
    .ack_cap_ev (ack_cap_ev),
    .advance_ev (advance_ev),
    .done_ev    (done_ev),
    .abort_ev   (abort_ev),
    .busy       (busy),
    .scl        (sck),
    .tw_q       (tw_q),
    .dir_q      (dir_q),
    .line_low   (line_low),
    .data_phase (data_phase),
    .in_ack     (in_ack)
  );

  bss_shifter #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_ev    (load_ev),
    .load_tx    (dir_tx),
    .load_val   (pend),
    .tx_q       (dir_q),
    .bit_cap_ev (bit_cap_ev),
    .ack_cap_ev (ack_cap_ev),
    .advance_ev (advance_ev),
    .latch_ev   (done_ev | abort_ev),
    .sd_in      (sd_in),
    .tx_bit     (tx_bit),
    .rxb        (rxb),
    .ack_rcvd   (ack_rcvd)
  );

  assign want   = line_level(line_low, data_phase, in_ack, dir_q, tx_bit, ack_send);
  assign sd_out = (busy & tw_q) ? 1'b0 : want;
  assign sd_oe  = busy & (tw_q ? ~want : dir_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= done_ev;
  end

endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int DW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic busy,
  input logic sck,
  input logic irq,
  input logic tx_ready,
  input logic txb_wr,
  input logic dir_tx,
  input logic load_ev,
  input logic done_ev,
  input logic abort_ev,
  input logic tw_q,
  input logic dir_q,
  input logic sd_out,
  input logic sd_oe
);

  p_idle_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  p_hold_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !busy);

  p_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txb_wr |=> tx_ready);

  p_take_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && dir_tx && !txb_wr) |=> !tx_ready);

  p_tx_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && dir_tx) |-> tx_ready);

  p_irq_follows_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> irq);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_no_irq_on_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !irq);

  p_open_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tw_q) |-> !sd_out);

  p_sync_rx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tw_q && !dir_q) |-> !sd_oe);

endmodule

bind bss_top bss_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold     (hold),
  .busy     (busy),
  .sck      (sck),
  .irq      (irq),
  .tx_ready (tx_ready),
  .txb_wr   (txb_wr),
  .dir_tx   (dir_tx),
  .load_ev  (load_ev),
  .done_ev  (done_ev),
  .abort_ev (abort_ev),
  .tw_q     (tw_q),
  .dir_q    (dir_q),
  .sd_out   (sd_out),
  .sd_oe    (sd_oe)
);

// File: tb/tb_bss_top.sv
module tb_bss_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_tick = 1'b0;
  logic hold = 1'b1;
  logic dir_tx = 1'b1;
  logic [1:0] mode = 2'd0;
  logic ack_send = 1'b0;
  logic txb_wr = 1'b0;
  logic [DW-1:0] txb_data = '0;
  logic sd_in;
  logic sd_out, sd_oe, sck, tx_ready, busy, ack_rcvd, irq;
  logic [DW-1:0] rxb;

  logic tw_b = 1'b0;
  logic slv_bit = 1'b1;
  logic [8:0] slv_sr = 9'h1FF;
  logic [8:0] cap = '0;
  int ncap = 0, nstart = 0, nstop = 0;
  logic oe_bad = 1'b0, od_bad = 1'b0;
  logic prev_sck = 1'b1, prev_line = 1'b1;
  int nchk = 0, nfail = 0;

  wire wired = (sd_oe ? sd_out : 1'b1) & slv_bit;
  assign sd_in = tw_b ? wired : slv_bit;

  bss_top #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .shift_tick(shift_tick), .hold(hold),
    .dir_tx(dir_tx), .mode(mode), .ack_send(ack_send), .txb_wr(txb_wr),
    .txb_data(txb_data), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .sck(sck), .rxb(rxb), .tx_ready(tx_ready), .busy(busy),
    .ack_rcvd(ack_rcvd), .irq(irq)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // half-bit tick on every other cycle
  initial forever begin
    @(negedge clk);
    shift_tick = ~shift_tick;
  end

  // slave: presents its next bit on each falling clock
  initial forever begin
    @(negedge sck);
    slv_bit = slv_sr[8];
    slv_sr  = {slv_sr[7:0], 1'b1};
  end

  // capture line level on each rising clock
  initial forever begin
    @(posedge sck);
    if (rst_n) begin
      ncap++;
      if (ncap <= 9) cap = {cap[7:0], (tw_b ? wired : sd_out)};
    end
  end

  // start/stop and output-enable monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (tw_b && prev_sck && sck && (prev_line !== wired)) begin
        if (wired) nstop++;
        else nstart++;
      end
      if (busy && !tw_b && !dir_tx && sd_oe) oe_bad = 1'b1;
      if (busy && tw_b && sd_out) od_bad = 1'b1;
    end
    prev_sck  = sck;
    prev_line = wired;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    cap = '0; ncap = 0; nstart = 0; nstop = 0; oe_bad = 1'b0; od_bad = 1'b0;
  endtask

  task automatic write_txb(input logic [DW-1:0] d);
    txb_data = d;
    txb_wr = 1'b1;
    @(negedge clk);
    txb_wr = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    bit got;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (irq) begin
        got = 1;
        break;
      end
    end
    chk(req, got, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 sck", sck, 1);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rxb", rxb, 0);
    chk("R1 ack_rcvd", ack_rcvd, 0);
    chk("R1 sd_oe", sd_oe, 0);
  endtask

  task automatic t_hold();
    dir_tx = 1'b1; mode = 2'd0; tw_b = 1'b0;
    write_txb(8'hC6);
    chk("R3 ready set", tx_ready, 1);
    repeat (20) @(negedge clk);
    chk("R2 held busy", busy, 0);
    chk("R2 held sck", sck, 1);
  endtask

  task automatic t_sync_tx_collide();
    bit started;
    clr_mon();
    slv_sr = {8'h3A, 1'b1};
    hold = 1'b0;
    started = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy) begin started = 1; break; end
    end
    chk("R4 tx start", started, 1);
    chk("R3 take clears", tx_ready, 0);
    write_txb(8'h59);
    chk("R3 write while busy", tx_ready, 1);
    wait_irq("R6 frame1 irq");
    chk("R5 msb first", cap[7:0], 8'hC6);
    chk("R5 eight rises", ncap, 8);
    chk("R6 rxb", rxb, 8'h3A);
    clr_mon();
    slv_sr = {8'h11, 1'b1};
    @(negedge clk);
    chk("R6 irq one cycle", irq, 0);
    // this write lands on the edge where frame 2 takes 8'h59
    txb_data = 8'hE1;
    txb_wr = 1'b1;
    @(negedge clk);
    txb_wr = 1'b0;
    chk("R3 collide busy", busy, 1);
    chk("R3 collide ready", tx_ready, 1);
    wait_irq("R6 frame2 irq");
    chk("R3 frame2 old byte", cap[7:0], 8'h59);
    chk("R6 frame2 rxb", rxb, 8'h11);
    clr_mon();
    wait_irq("R6 frame3 irq");
    chk("R3 frame3 new byte", cap[7:0], 8'hE1);
    repeat (12) @(negedge clk);
    chk("R4 no ready no start", busy, 0);
    chk("R4 ready low", tx_ready, 0);
    hold = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sync_rx();
    dir_tx = 1'b0;
    clr_mon();
    slv_sr = {8'hA5, 1'b1};
    hold = 1'b0;
    wait_irq("R4 rx starts");
    hold = 1'b1;
    chk("R6 rx rxb", rxb, 8'hA5);
    chk("R5 rx oe low", oe_bad, 0);
    repeat (6) @(negedge clk);
    chk("R2 rx stopped", busy, 0);
  endtask

  task automatic t_abort();
    bit seen;
    dir_tx = 1'b0;
    clr_mon();
    slv_sr = {8'hA5, 1'b1};
    hold = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ncap == 3) break;
    end
    hold = 1'b1;
    @(negedge clk);
    chk("R7 abort idle", busy, 0);
    chk("R7 abort sck", sck, 1);
    chk("R7 partial rxb", rxb, 8'h05);
    seen = irq;
    @(negedge clk);
    seen = seen | irq;
    chk("R7 no irq", seen, 0);
  endtask

  task automatic run_tw(input logic [1:0] md, input logic tx, input logic [8:0] slv,
                        input logic [DW-1:0] d);
    mode = md; tw_b = 1'b1; dir_tx = tx;
    if (tx) write_txb(d);
    clr_mon();
    slv_sr = slv;
    hold = 1'b0;
    wait_irq("R8 tw irq");
    hold = 1'b1;
    chk("R8 start", nstart, 1);
    chk("R8 stop", nstop, 1);
    chk("R8 open drain", od_bad, 0);
  endtask

  task automatic t_tw9_tx();
    run_tw(2'd1, 1'b1, {8'hFF, 1'b1}, 8'h0F);
    chk("R9 nack stored", ack_rcvd, 1);
    chk("R9 nack line", cap, {8'h0F, 1'b1});
    run_tw(2'd1, 1'b1, {8'hFF, 1'b0}, 8'h96);
    chk("R9 ack line", cap, {8'h96, 1'b0});
    chk("R9 ten rises", ncap, 10);
    chk("R9 ack stored", ack_rcvd, 0);
    chk("R6 tw rxb", rxb, 8'h96);
  endtask

  task automatic t_tw9_rx();
    ack_send = 1'b0;
    run_tw(2'd1, 1'b0, {8'h5C, 1'b1}, 8'h00);
    chk("R9 rx data", rxb, 8'h5C);
    chk("R9 rx ack driven", cap, {8'h5C, 1'b0});
    chk("R9 rx ack_rcvd kept", ack_rcvd, 0);
  endtask

  task automatic t_tw8();
    run_tw(2'd2, 1'b1, {8'hFF, 1'b1}, 8'hA3);
    chk("R10 nine rises", ncap, 9);
    chk("R10 data", cap[8:1], 8'hA3);
    chk("R10 ack_rcvd kept", ack_rcvd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hold();
    t_sync_tx_collide();
    t_sync_rx();
    t_abort();
    t_tw9_tx();
    t_tw9_rx();
    t_tw8();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule